// File: doc/BRIEF.md
# Multi-mode host bus interface

This block is a byte-wide microprocessor bus slave in front of a 256-entry register file. It accepts three host bus styles through one set of pins. Two of them have separate address and data lines: one uses a single data strobe together with a read/write direction line (Motorola style), the other uses separate active-low read and write strobes (Intel style). The third is an Intel-style multiplexed style, in which the register address travels on the data lines and is captured by an address latch enable (ALE) strobe.

The bus style is not programmed. It is inferred from ALE. A fixed high level on ALE when reset is released selects the strobe-with-direction style. A fixed low level selects the two-strobe style. The first rising edge of ALE after reset moves the block into the multiplexed style, and the block stays there until the next reset. ALE, chip select and the two strobe pins are brought into the system clock domain with a synchronizer. All decoding uses the synchronized copies. On the inner side, the block drives a plain register-file port: an address, write data, a write-enable pulse and a read-enable pulse. It takes combinational read data back from that port.

Top module: `hostbus_slave`

## Requirements
- R1: The style is taken from the synchronized ALE level during reset and held after release. ALE high (1) selects the strobe-with-direction style. In that style a low pulse on `bus_strb_b` while `bus_strb_a_n` stays high causes no write. ALE low (0) selects the two-strobe style.
- R2: In the two-strobe style, a write is committed when `bus_strb_b` (active-low write strobe) rises while `bus_cs_n` is low. `reg_addr` is `bus_addr` and `reg_wdata` is `bus_din`.
- R3: The data output enable `bus_doe` is 1 only while chip select and the read condition are both active. While it is 1, `bus_dout` carries `reg_rdata` for the addressed register. Otherwise `bus_doe` is 0 and `bus_dout` is 0.
- R4: In the strobe-with-direction style, `bus_strb_a_n` is the active-low data strobe and `bus_strb_b` is the direction (1 = read, 0 = write). A write commits when the data strobe rises with the direction at 0.
- R5: The first synchronized rising edge of ALE after reset release switches to the multiplexed style. The block stays there whatever ALE does afterwards, until the next reset.
- R6: In the multiplexed style, the register address is captured from `bus_din[7:0]` on each synchronized falling edge of ALE, and `bus_addr` is ignored.
- R7: ALE edges while `rst_n` is low neither select the multiplexed style nor change the outcome. Only the level present at release counts.
- R8: In the multiplexed style, an access made before any ALE falling edge since reset uses register address 0.
- R9: Strobe activity while `bus_cs_n` is high causes no write and does not raise `bus_doe`.
- R10: Each write strobe produces exactly one single-cycle `reg_we` pulse.
- R11: While reset is held, `reg_we`, `reg_re` and `bus_doe` are 0 and `bus_dout` is 0.
- R12: Each read access produces exactly one single-cycle `reg_re` pulse, in the cycle `bus_doe` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_strb_a_n | input | 1 | Read strobe (two-strobe and multiplexed styles) or data strobe (direction style), active low |
| bus_strb_b | input | 1 | Active-low write strobe, or read/write direction (1 = read) in the direction style |
| bus_ale | input | 1 | Address latch enable; its level and edges also pick the bus style |
| bus_addr | input | 8 | Register address for the non-multiplexed styles |
| bus_din | input | 8 | Write data; in the multiplexed style also the address at the ALE fall |
| bus_dout | output | 8 | Read data toward the host, 0 when not driven |
| bus_doe | output | 1 | Data output enable toward the host |
| reg_addr | output | 8 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_we | output | 1 | Register-file write pulse |
| reg_re | output | 1 | Register-file read pulse |
| reg_rdata | input | 8 | Register-file read data for `reg_addr` |

## Verification
A table of write and read vectors over scattered addresses, including 0x00 and 0xFF, is applied in the two-strobe style. This shows that address and data reach the register port intact and that each strobe commits only once. The same register traffic is then repeated after resets with ALE high, with ALE toggling inside reset, and with ALE rising after reset. Each of these is chosen so that a wrong style decision writes or reads a different register: a two-strobe write pattern is inert in the direction style, and a latched address of 0 collides with a known value. A read of a register with a distinct stored value, taken long after the last ALE edge and again after a fresh reset, separates the sticky multiplexed style from a fallback to the non-multiplexed ones.

// File: rtl/hb_pkg.sv
// Shared types for the host bus interface.
// Assumes: only the three bus styles below ever exist.
package hb_pkg;

    // Bus style decoded from the ALE pin.
    typedef enum logic [1:0] {
        BUS_MOT_SEP = 2'd0,   // separate lines, data strobe plus direction
        BUS_INT_SEP = 2'd1,   // separate lines, read and write strobes
        BUS_INT_MUX = 2'd2    // multiplexed address/data, ALE latched
    } bus_mode_e;

endpackage

// File: rtl/hb_sync.sv
// Multi-stage synchronizer for a group of asynchronous control pins.
// Assumes: every bit is an independent slow control level; STAGES >= 2.
// The flops carry no reset on purpose, so the pin levels keep flowing
// while reset is held and no false edge appears at release.
module hb_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the pin group through the stage chain.
    always_ff @(posedge clk) begin
        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_in};
    end

    assign d_out = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/hb_mode_ctrl.sv
// Bus style selection from the synchronized ALE.
// The style follows the ALE level during reset and freezes at release.
// After release the first ALE rise selects the multiplexed style
// for good. It also reports ALE falling edges once reset is released.
// Assumes: ale_s is already synchronized to clk.
module hb_mode_ctrl
    import hb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ale_s,
    output bus_mode_e mode,
    output logic      ale_fall
);
    logic ale_q;

    // Previous ALE, tracked through reset so reset-time edges vanish.
    always_ff @(posedge clk) begin
        ale_q <= ale_s;
    end

    // Style register: level-sampled in reset, sticky multiplexed after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= ale_s ? BUS_MOT_SEP : BUS_INT_SEP;
        end else if (ale_s && !ale_q) begin
            mode <= BUS_INT_MUX;
        end
    end

    // Falling-edge flag, masked during reset.
    always_comb begin
        ale_fall = rst_n && ale_q && !ale_s;
    end

    // R5: once multiplexed, always multiplexed until reset.
    p_mux_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BUS_INT_MUX) |=> (mode == BUS_INT_MUX));

    // R5, R7: entry into the multiplexed style only follows a seen rise.
    p_mux_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BUS_INT_MUX && $past(mode) != BUS_INT_MUX)
        |-> $past(ale_s && !ale_q));

    // R1: the non-multiplexed choice never flips between the two.
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != BUS_INT_MUX) |=> (mode == $past(mode) || mode == BUS_INT_MUX));

endmodule

// File: rtl/hb_addr_latch.sv
// Address source selection.
// In the multiplexed style the address comes from a latch that is
// loaded from the data lines on each ALE fall. In the other styles it
// comes straight from the address lines.
// Assumes: ADDR_W <= DATA_W; the data lines hold the address
// until the synchronized fall has been seen.
module hb_addr_latch
    import hb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         mode,
    input  logic              ale_fall,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] cur_addr
);
    logic [ADDR_W-1:0] alat_q;

    // Load the multiplexed address; zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alat_q <= '0;
        end else if (ale_fall && mode == BUS_INT_MUX) begin
            alat_q <= bus_din[ADDR_W-1:0];
        end
    end

    // Pick the address source for the current style.
    always_comb begin
        cur_addr = (mode == BUS_INT_MUX) ? alat_q : bus_addr;
    end

    // R6: the latched address moves only on an ALE fall.
    p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_fall |=> $stable(alat_q));

    // R8: the latch starts from address 0 when reset is released.
    p_latch_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (alat_q == '0));

endmodule

// File: rtl/hb_access.sv
// Strobe decode and register-file port.
// The strobe pins are read according to the bus style. A write
// commits once, at the trailing edge of the write strobe, while chip
// select is still active. A read drives the host data bus while chip
// select and the read condition hold, and pulses read enable once.
// Assumes: all strobe inputs are synchronized; the address and data
// lines are stable while the synchronized strobes move.
module hb_access
    import hb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         mode,
    input  logic              cs_n_s,
    input  logic              strb_a_n_s,
    input  logic              strb_b_s,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe
);
    logic cs_act;
    logic rd_req;
    logic wr_str;
    logic rd_act;
    logic commit;
    logic wr_str_q;
    logic rd_q;
    logic rd_qq;

    // Interpret the strobe pins for the current bus style.
    always_comb begin
        cs_act = !cs_n_s;
        if (mode == BUS_MOT_SEP) begin
            rd_req = !strb_a_n_s && strb_b_s;
            wr_str = !strb_a_n_s && !strb_b_s;
        end else begin
            rd_req = !strb_a_n_s;
            wr_str = !strb_b_s;
        end
        rd_act = cs_act && rd_req;
        commit = wr_str_q && !wr_str && cs_act;
    end

    // Strobe history, register-port outputs and read window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_str_q  <= 1'b0;
            rd_q      <= 1'b0;
            rd_qq     <= 1'b0;
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else begin
            wr_str_q <= wr_str;
            rd_q     <= rd_act;
            rd_qq    <= rd_q;
            reg_we   <= commit;
            reg_addr <= cur_addr;
            if (commit) begin
                reg_wdata <= bus_din;
            end
        end
    end

    // Read pulse at the start of the read window; gated data drive.
    always_comb begin
        reg_re   = rd_q && !rd_qq;
        bus_doe  = rd_q;
        bus_dout = rd_q ? reg_rdata : '0;
    end

    // R10: a write pulse lasts one cycle.
    p_we_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R12: a read pulse lasts one cycle and coincides with the drive.
    p_re_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> (bus_doe && $past(!bus_doe)));

    // R9: no write without chip select in the deciding cycle.
    p_we_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(!cs_n_s));

    // R3, R9: no bus drive without chip select in the deciding cycle.
    p_doe_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> $past(!cs_n_s));

endmodule

// File: rtl/hostbus_slave.sv
// Multi-mode host bus slave in front of a byte-wide register file.
// Synchronizes the bus control pins and derives the bus style from
// ALE. It picks the address source and decodes the strobes into a
// simple register-file port.
// Assumes: the host keeps address and data stable for several clocks
// around each strobe edge, and ALE is static in the non-multiplexed
// styles.
module hostbus_slave
    import hb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_strb_a_n,
    input  logic              bus_strb_b,
    input  logic              bus_ale,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int CTRL_W = 4;

    logic [CTRL_W-1:0] ctrl_raw;
    logic [CTRL_W-1:0] ctrl_s;
    bus_mode_e         mode;
    logic              ale_fall;
    logic [ADDR_W-1:0] cur_addr;

    assign ctrl_raw = {bus_ale, bus_cs_n, bus_strb_a_n, bus_strb_b};

    hb_sync #(
        .WIDTH  (CTRL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .d_in  (ctrl_raw),
        .d_out (ctrl_s)
    );

    hb_mode_ctrl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale_s    (ctrl_s[3]),
        .mode     (mode),
        .ale_fall (ale_fall)
    );

    hb_addr_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .ale_fall (ale_fall),
        .bus_addr (bus_addr),
        .bus_din  (bus_din),
        .cur_addr (cur_addr)
    );

    hb_access #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_access (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .cs_n_s     (ctrl_s[2]),
        .strb_a_n_s (ctrl_s[1]),
        .strb_b_s   (ctrl_s[0]),
        .cur_addr   (cur_addr),
        .bus_din    (bus_din),
        .reg_rdata  (reg_rdata),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .bus_dout   (bus_dout),
        .bus_doe    (bus_doe)
    );

    // R11: the outputs leave reset quiet.
    p_quiet_after_reset_r11: assert property (@(posedge clk)
        $past(!rst_n) |-> (!reg_we && !bus_doe));

endmodule

// File: tb/hostbus_slave_tb.sv
module hostbus_slave_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1;
    logic       bus_strb_a_n = 1'b1;
    logic       bus_strb_b = 1'b1;
    logic       bus_ale = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_doe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic       reg_re;
    logic [7:0] reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int re_cnt = 0;
    logic [7:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_slave u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_cs_n     (bus_cs_n),
        .bus_strb_a_n (bus_strb_a_n),
        .bus_strb_b   (bus_strb_b),
        .bus_ale      (bus_ale),
        .bus_addr     (bus_addr),
        .bus_din      (bus_din),
        .bus_dout     (bus_dout),
        .bus_doe      (bus_doe),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_we       (reg_we),
        .reg_re       (reg_re),
        .reg_rdata    (reg_rdata)
    );

    // Register-file model behind the block.
    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_re) re_cnt <= re_cnt + 1;
    end
    assign reg_rdata = mem[reg_addr];

    // {is_write, addr, data}
    localparam logic [16:0] VEC [0:7] = '{
        {1'b1, 8'h10, 8'hA5}, {1'b1, 8'h11, 8'h5A},
        {1'b1, 8'hFF, 8'h3C}, {1'b1, 8'h00, 8'h81},
        {1'b0, 8'h10, 8'hA5}, {1'b0, 8'hFF, 8'h3C},
        {1'b0, 8'h11, 8'h5A}, {1'b0, 8'h00, 8'h81}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic lvl, input bit toggle);
        rst_n = 1'b0;
        bus_ale = lvl;
        if (toggle) begin
            for (int i = 0; i < 4; i++) begin
                bus_ale = ~bus_ale;
                cyc(2);
            end
            bus_ale = lvl;
        end
        cyc(6);
        rst_n = 1'b1;
        cyc(4);
    endtask

    // Two-strobe (and multiplexed) write: strb_b is the write strobe.
    task automatic sep_write(input logic [7:0] a, input logic [7:0] d, input logic cs);
        bus_addr = a; bus_din = d; bus_cs_n = cs; cyc(3);
        bus_strb_b = 1'b0; cyc(4);
        bus_strb_b = 1'b1; cyc(4);
        bus_cs_n = 1'b1; cyc(3);
    endtask

    // Read with strb_a_n low and strb_b high (valid in every style).
    task automatic any_read(input logic [7:0] a, input logic cs,
                            output logic doe, output logic [7:0] dat);
        bus_addr = a; bus_cs_n = cs; bus_strb_b = 1'b1; cyc(2);
        bus_strb_a_n = 1'b0; cyc(5);
        doe = bus_doe; dat = bus_dout;
        bus_strb_a_n = 1'b1; cyc(4);
        bus_cs_n = 1'b1; cyc(3);
    endtask

    // Direction-style write: direction low, then data strobe pulse.
    task automatic mot_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_din = d; bus_strb_b = 1'b0; bus_cs_n = 1'b0; cyc(3);
        bus_strb_a_n = 1'b0; cyc(4);
        bus_strb_a_n = 1'b1; cyc(4);
        bus_cs_n = 1'b1; bus_strb_b = 1'b1; cyc(3);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic doe;
        logic [7:0] dat;
        int w0;
        int r0;

        // R11: quiet outputs while reset is held.
        cyc(5);
        chk(!reg_we && !reg_re, "R11 strobes", {reg_we, reg_re}, 0);
        chk(!bus_doe && bus_dout == 8'h00, "R11 bus", {bus_doe, bus_dout}, 0);
        rst_n = 1'b1; cyc(4);   // ALE low: two-strobe style

        // Vector table in the two-strobe style: R2, R3, R10, R12.
        for (int i = 0; i < 8; i++) begin
            w0 = wr_cnt; r0 = re_cnt;
            if (VEC[i][16]) begin
                sep_write(VEC[i][15:8], VEC[i][7:0], 1'b0);
                chk(mem[VEC[i][15:8]] == VEC[i][7:0], "R2 write data", mem[VEC[i][15:8]], VEC[i][7:0]);
                chk(wr_cnt == w0 + 1, "R10 one write", wr_cnt - w0, 1);
            end else begin
                any_read(VEC[i][15:8], 1'b0, doe, dat);
                chk(doe && dat == VEC[i][7:0], "R3 read data", {doe, dat}, {1'b1, VEC[i][7:0]});
                chk(re_cnt == r0 + 1, "R12 one read", re_cnt - r0, 1);
            end
        end
        chk(!bus_doe && bus_dout == 8'h00, "R3 idle no drive", {bus_doe, bus_dout}, 0);

        // R9: strobes with chip select high.
        w0 = wr_cnt;
        sep_write(8'h10, 8'hEE, 1'b1);
        chk(wr_cnt == w0 && mem[8'h10] == 8'hA5, "R9 no write", mem[8'h10], 8'hA5);
        any_read(8'h10, 1'b1, doe, dat);
        chk(!doe && dat == 8'h00, "R9 no drive", {doe, dat}, 0);

        // R1, R4: ALE high at reset gives the direction style.
        do_reset(1'b1, 1'b0);
        w0 = wr_cnt;
        sep_write(8'h20, 8'hEE, 1'b0);
        chk(wr_cnt == w0, "R1 two-strobe write inert", wr_cnt - w0, 0);
        mot_write(8'h33, 8'hC3);
        chk(mem[8'h33] == 8'hC3 && wr_cnt == w0 + 1, "R4 direction write", mem[8'h33], 8'hC3);
        any_read(8'h33, 1'b0, doe, dat);
        chk(doe && dat == 8'hC3, "R4 direction read", dat, 8'hC3);

        // R7: ALE toggling in reset, low at release, stays two-strobe.
        do_reset(1'b0, 1'b1);
        sep_write(8'h44, 8'h6B, 1'b0);
        chk(mem[8'h44] == 8'h6B, "R7 not multiplexed", mem[8'h44], 8'h6B);
        chk(mem[8'h00] == 8'h81, "R7 addr 0 untouched", mem[8'h00], 8'h81);

        // R8, R6: ALE rises, access before any fall goes to address 0.
        sep_write(8'h77, 8'h11, 1'b0);
        bus_ale = 1'b1; cyc(5);
        sep_write(8'h77, 8'h9E, 1'b0);
        chk(mem[8'h00] == 8'h9E, "R8 address zero", mem[8'h00], 8'h9E);
        chk(mem[8'h77] == 8'h11, "R6 address lines ignored", mem[8'h77], 8'h11);

        // R6: address latched from data lines at the ALE fall.
        bus_din = 8'h80; cyc(2);
        bus_ale = 1'b0; cyc(5);
        sep_write(8'h12, 8'h5D, 1'b0);
        chk(mem[8'h80] == 8'h5D, "R6 latched write", mem[8'h80], 8'h5D);
        any_read(8'h33, 1'b0, doe, dat);
        chk(doe && dat == 8'h5D, "R6 latched read", dat, 8'h5D);

        // R5: ALE quiet for a long time, style stays multiplexed.
        cyc(40);
        any_read(8'h33, 1'b0, doe, dat);
        chk(dat == 8'h5D, "R5 sticky", dat, 8'h5D);

        // R5: a new reset with ALE low returns to the two-strobe style.
        do_reset(1'b0, 1'b0);
        any_read(8'h33, 1'b0, doe, dat);
        chk(doe && dat == 8'hC3, "R5 reset leaves multiplexed", dat, 8'hC3);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule